// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block drives one pulse-width-modulated output from a free-running period counter of `CNT_W` bits. The period is 2^CNT_W clocks, and the output is active while the count is below the duty value in force. Software writes a control word (enable, output inversion, update mode), a duty value and an interrupt acknowledge through a simple single-cycle write port.

A written duty value first lands in a shadow register. In atomic mode it waits there and is copied into the compare register on the clock where the counter wraps to zero. The output therefore shows only whole periods at the old duty followed by whole periods at the new one. In immediate mode the compare register takes the value on the next clock. Because the output is cut off whenever the count is at or above the duty, lowering the duty mid-period ends the high phase early instead of stretching it. A sticky interrupt flag reports each moment a new duty comes into force.

The control path is a three-state machine. `ST_IDLE` is the disabled state. `ST_RUN` is running with nothing pending. `ST_PEND` is running with an atomic update waiting. The transitions are:
- enable: `ST_IDLE`→`ST_RUN`, which loads the shadow into the compare register.
- atomic duty write: `ST_RUN`→`ST_PEND`.
- boundary transfer: `ST_PEND`→`ST_RUN` at the wrap.
- immediate duty write: `ST_PEND`→`ST_RUN`, or `ST_RUN`→`ST_RUN`, loading the written value.
- disable: any running state→`ST_IDLE`.

Top module: `pwm_dbuf`

## Requirements
- R1: After reset the output is low, the interrupt is low and the generator is disabled.
- R2: While enabled, the counter advances by one every clock and wraps after 2^CNT_W clocks. The output is active in exactly the clocks whose count is below the active duty.
- R3: A duty of 0 gives a constant inactive output. Any duty of 2^CNT_W or more (the top bit of the `CNT_W+1`-bit field set) gives a constant active output.
- R4: Control bit 1 (invert) swaps the levels. The active level is 1 when it is clear and 0 when it is set, and the inactive level is the opposite.
- R5: With control bit 2 clear (atomic), a write to address 1 does not change the output before the counter wraps. The new duty governs the first clock of the next period. A second atomic write landing on the wrap clock waits for the following wrap.
- R6: With control bit 2 set (immediate), a write to address 1 governs the output from the next clock. If the count is already at or above the new duty, the output goes inactive, so no period is stretched.
- R7: Writing address 0 with bit 0 clear makes the output inactive on the next clock, whatever the count. A pending atomic update is dropped.
- R8: Writing address 0 with bit 0 set while disabled starts the counter at 0 and loads the last written duty into force at the same clock.
- R9: The interrupt becomes 1 on every clock at which a duty comes into force (enable, wrap transfer, immediate write). It stays 1 until a write to address 2 with bit 0 set. A set and a clear on the same clock leave it set.
- R10: A write to address 1 while disabled leaves the output inactive and the interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one register per clock |
| wr_addr | input | 2 | 0 control, 1 duty, 2 interrupt acknowledge, 3 unused |
| wr_data | input | CNT_W+1 | Write data |
| pwm_out | output | 1 | PWM output |
| irq | output | 1 | Sticky new-setting-active flag |

## Verification
The bench builds the block with `CNT_W` = 4, so a period is 16 clocks and the duty field has 5 bits. Every duty from 0 to 16, plus an over-range value, can then be swept under both polarities, with the high time of each whole period counted and compared with the arithmetic value. The short period also lets a long pseudo-random run of writes cross hundreds of wraps. That run lands atomic writes, disables and acknowledges on the wrap clock itself, and every cycle is compared against a register-level model in the bench.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_PEND = 2'd2
    } pwm_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DUTY = 2'd1;
    localparam logic [1:0] ADDR_ACK  = 2'd2;

    localparam int CTL_EN  = 0;
    localparam int CTL_INV = 1;
    localparam int CTL_IMM = 2;

endpackage

// File: rtl/pwm_dbuf_cnt.sv
module pwm_dbuf_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign wrap = run && (cnt == CNT_MAX);

endmodule

// File: rtl/pwm_dbuf_out.sv
module pwm_dbuf_out #(
    parameter int CNT_W = 8,
    parameter int DW    = CNT_W + 1
) (
    input  logic             en,
    input  logic             inv,
    input  logic [CNT_W-1:0] cnt,
    input  logic [DW-1:0]    act,
    output logic             pwm_out
);
    logic below;

    // Output is on strictly below the match; at or above it is off.
    always_comb begin
        below = ({1'b0, cnt} < act);
        if (en) begin
            pwm_out = below ^ inv;
        end else begin
            pwm_out = inv;
        end
    end

endmodule

// File: rtl/pwm_dbuf_ctrl.sv
module pwm_dbuf_ctrl
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DW    = CNT_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wrap,
    output logic          en,
    output logic          inv,
    output logic [DW-1:0] act,
    output logic          irq
);
    pwm_state_e    state_q;
    pwm_state_e    state_d;
    logic [DW-1:0] shadow_q;
    logic          imm_q;
    logic          act_ld;
    logic          act_from_sh;
    logic          ctrl_wr;
    logic          duty_wr;
    logic          ack_wr;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign duty_wr = wr_en && (wr_addr == ADDR_DUTY);
    assign ack_wr  = wr_en && (wr_addr == ADDR_ACK) && wr_data[0];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and load decisions
    always_comb begin
        state_d     = state_q;
        act_ld      = 1'b0;
        act_from_sh = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr && wr_data[CTL_EN]) begin
                    state_d     = ST_RUN;
                    act_ld      = 1'b1;
                    act_from_sh = 1'b1;
                end
            end
            ST_RUN: begin
                if (ctrl_wr && !wr_data[CTL_EN]) begin
                    state_d = ST_IDLE;
                end else if (duty_wr && imm_q) begin
                    act_ld = 1'b1;
                end else if (duty_wr) begin
                    state_d = ST_PEND;
                end
            end
            ST_PEND: begin
                if (ctrl_wr && !wr_data[CTL_EN]) begin
                    state_d = ST_IDLE;
                end else if (duty_wr && imm_q) begin
                    state_d = ST_RUN;
                    act_ld  = 1'b1;
                end else if (wrap) begin
                    state_d     = duty_wr ? ST_PEND : ST_RUN;
                    act_ld      = 1'b1;
                    act_from_sh = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Registers driven by the machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            act      <= '0;
            inv      <= 1'b0;
            imm_q    <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (duty_wr) begin
                shadow_q <= wr_data;
            end
            if (ctrl_wr) begin
                inv   <= wr_data[CTL_INV];
                imm_q <= wr_data[CTL_IMM];
            end
            if (act_ld) begin
                act <= act_from_sh ? shadow_q : wr_data;
            end
            if (act_ld) begin
                irq <= 1'b1;
            end else if (ack_wr) begin
                irq <= 1'b0;
            end
        end
    end

    assign en = (state_q != ST_IDLE);

endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf #(
    parameter  int CNT_W = 8,
    localparam int DW    = CNT_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          pwm_out,
    output logic          irq
);
    logic             en_w;
    logic             inv_w;
    logic [DW-1:0]    act_w;
    logic [CNT_W-1:0] cnt_w;
    logic             wrap_w;

    pwm_dbuf_ctrl #(.CNT_W(CNT_W), .DW(DW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wrap    (wrap_w),
        .en      (en_w),
        .inv     (inv_w),
        .act     (act_w),
        .irq     (irq)
    );

    pwm_dbuf_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en_w),
        .cnt   (cnt_w),
        .wrap  (wrap_w)
    );

    pwm_dbuf_out #(.CNT_W(CNT_W), .DW(DW)) u_out (
        .en      (en_w),
        .inv     (inv_w),
        .cnt     (cnt_w),
        .act     (act_w),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/pwm_dbuf_sva.sv
module pwm_dbuf_sva
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DW    = CNT_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [DW-1:0]    wr_data,
    input logic             pwm_out,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic [DW-1:0]    act,
    input logic             en,
    input logic             inv,
    input logic             wrap
);
    logic [CNT_W-1:0] cnt_inc;
    assign cnt_inc = cnt + 1'b1;

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> (cnt == $past(cnt_inc)));

    assert_zero_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && act == '0) |-> (pwm_out == inv));

    assert_full_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && act[DW-1]) |-> (pwm_out == !inv));

    assert_act_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$stable(act)) |->
            $past(wrap || (wr_en && wr_addr == ADDR_DUTY)));

    assert_disable_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL && !wr_data[CTL_EN]) |=>
            (pwm_out == $past(wr_data[CTL_INV])));

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && wr_addr == ADDR_ACK && wr_data[0])) |=> irq);

    assert_irq_on_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$stable(act)) |-> irq);

endmodule

bind pwm_dbuf pwm_dbuf_sva #(.CNT_W(CNT_W), .DW(DW)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_out (pwm_out),
    .irq     (irq),
    .cnt     (cnt_w),
    .act     (act_w),
    .en      (en_w),
    .inv     (inv_w),
    .wrap    (wrap_w)
);

// File: tb/pwm_dbuf_bench.sv
module pwm_dbuf_bench;
    localparam int CW = 4;
    localparam int DW = CW + 1;
    localparam int M  = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic          pwm_out;
    logic          irq;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    int  m_cnt = 0, m_act = 0, m_sh = 0;
    bit  m_en = 0, m_inv = 0, m_imm = 0, m_pend = 0, m_irq = 0;

    always #10 clk = ~clk;

    pwm_dbuf #(.CNT_W(CW)) u_pwm_dbuf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .irq(irq)
    );

    task automatic check(input string tag, input int act_v, input int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act_v, exp_v, $time);
        end
    endtask

    function automatic int exp_out();
        if (!m_en) return int'(m_inv);
        return int'((m_cnt < m_act) ^ m_inv);
    endfunction

    // Register-level reference, applied once per clock edge
    task automatic model(input bit we, input logic [1:0] a, input logic [DW-1:0] d);
        bit set;
        bit wrp;
        bit dis;
        int nc;
        set = 0;
        wrp = m_en && (m_cnt == M - 1);
        dis = we && a == 2'd0 && !d[0];
        nc  = m_en ? (m_cnt + 1) % M : 0;
        if (wrp && m_pend && !dis) begin m_act = m_sh; m_pend = 0; set = 1; end
        if (we && a == 2'd0) begin
            if (!m_en && d[0]) begin m_act = m_sh; set = 1; end
            if (!d[0]) m_pend = 0;
            m_en = d[0]; m_inv = d[1]; m_imm = d[2];
        end
        if (we && a == 2'd1) begin
            m_sh = int'(d);
            if (m_en) begin
                if (m_imm) begin m_act = int'(d); m_pend = 0; set = 1; end
                else m_pend = 1;
            end
        end
        if (we && a == 2'd2 && d[0]) m_irq = 0;
        if (set) m_irq = 1;
        m_cnt = nc;
    endtask

    // One clock: drive at the falling edge, update model at the rising edge,
    // compare at the next falling edge.
    task automatic cyc(input bit we, input logic [1:0] a, input logic [DW-1:0] d,
                       input string tag);
        wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        model(we, a, d);
        @(negedge clk);
        wr_en = 1'b0;
        check({tag, " out"}, int'(pwm_out), exp_out());
        check({tag, " irq"}, int'(irq), int'(m_irq));
    endtask

    task automatic idle(input int n, input string tag, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 2'd3, '0, tag);
            highs += int'(pwm_out);
        end
    endtask

    function automatic logic [DW-1:0] ctl(input bit e, input bit v, input bit im);
        return DW'({im, v, e});
    endfunction

    initial begin
        int h;
        int h0;
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 out after reset", int'(pwm_out), 0);
        check("R1 irq after reset", int'(irq), 0);

        // R10: duty write while disabled does nothing visible
        cyc(1'b1, 2'd1, DW'(9), "R10");
        idle(5, "R10", h);
        check("R10 no active clocks", h, 0);

        // R2 R3 R4 R8 R9 R7: full sweep of duty and polarity
        for (int v = 0; v < 2; v++) begin
            for (int d = 0; d <= M + 1; d++) begin
                cyc(1'b1, 2'd1, DW'(d), "R10");
                cyc(1'b1, 2'd0, ctl(1, v[0], 0), "R8");
                h0 = int'(pwm_out);
                check("R8 irq on enable", int'(irq), 1);
                idle(M - 1, "R2", h);
                h += h0;
                if (v == 0) check("R2 R3 active clocks", h, (d > M) ? M : d);
                else        check("R4 R3 active clocks inv", M - h, (d > M) ? M : d);
                idle(M, "R2", h);
                if (v == 0) check("R2 second period", h, (d > M) ? M : d);
                else        check("R4 second period", M - h, (d > M) ? M : d);
                cyc(1'b1, 2'd2, DW'(1), "R9");
                check("R9 cleared", int'(irq), 0);
                cyc(1'b1, 2'd0, ctl(0, v[0], 0), "R7");
                check("R7 inactive", int'(pwm_out), v);
            end
        end

        // R5: atomic change mid-period
        cyc(1'b1, 2'd1, DW'(12), "R5");
        cyc(1'b1, 2'd0, ctl(1, 0, 0), "R5");
        cyc(1'b1, 2'd2, DW'(1), "R9");
        idle(3, "R5", h);
        cyc(1'b1, 2'd1, DW'(3), "R5");
        check("R5 old duty still high", int'(pwm_out), 1);
        check("R5 no irq before wrap", int'(irq), 0);
        idle(M - 5, "R5", h);
        check("R5 rest of period old duty", h, 12 - 5);
        idle(M, "R5", h);
        check("R5 new period new duty", h, 3);
        check("R9 irq after transfer", int'(irq), 1);
        cyc(1'b1, 2'd0, ctl(0, 0, 0), "R7");

        // R6: immediate reduction below the count
        cyc(1'b1, 2'd1, DW'(12), "R6");
        cyc(1'b1, 2'd0, ctl(1, 0, 1), "R6");
        h0 = int'(pwm_out);
        idle(8, "R6", h);
        h += h0;
        cyc(1'b1, 2'd1, DW'(4), "R6");
        check("R6 drops at once", int'(pwm_out), 0);
        idle(M - 10, "R6", h0);
        check("R6 no stretched period", h + h0, 9);
        idle(M, "R6", h);
        check("R6 next period", h, 4);

        // R7: disable mid-high with a pending update
        cyc(1'b1, 2'd0, ctl(1, 1, 0), "R7");
        cyc(1'b1, 2'd1, DW'(16), "R7");
        cyc(1'b1, 2'd0, ctl(0, 1, 0), "R7");
        check("R7 inactive inverted", int'(pwm_out), 1);

        // Pseudo-random writes against the model
        lf = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[2:0] == 3'd0)
                cyc(1'b1, lf[5:4], lf[12:8], "R5 R9 random");
            else
                cyc(1'b0, 2'd3, '0, "R2 R6 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule